// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style processor. Each cycle it may accept one operation: a working-register value W, a second operand taken from either a file-register value or an 8-bit literal, a 4-bit operation code, a destination bit and the current status bits (carry C, digit carry DC, zero Z). One clock edge later it presents the 8-bit result, whether that result goes back to W or to the file register, the new status bits, and a mask that names the status bits the operation was allowed to change.

Subtraction is built as addition of the two's complement of W, so after a subtract C means "no borrow" and DC means "no borrow out of the low nibble". Rotates move data through the carry bit. Every operation owns a fixed subset of the status bits, and the bits it does not own come out exactly as they went in. Instruction decode, register banking and program flow belong to the surrounding core.

Top module: `accu_alu`

## Requirements
- R1: While the synchronous active-high reset is asserted, every output is driven to zero at the next rising edge.
- R2: Operation code 0 (add) returns operand + W modulo 256; C is the carry out of bit 7, DC the carry out of bit 3, Z is set for a zero result; the mask marks C, DC and Z.
- R3: Operation code 1 (subtract) returns operand − W modulo 256; C is 1 when operand ≥ W, DC is 1 when the operand's low nibble ≥ W's low nibble, Z is set for a zero result; the mask marks C, DC and Z.
- R4: Codes 2, 3, 4 return operand AND W, operand OR W and operand XOR W; they update only Z.
- R5: Code 5 returns the bitwise complement of the operand, code 6 operand + 1 and code 7 operand − 1 (both modulo 256); each updates only Z.
- R6: Code 9 rotates left through carry (bit 7 into C, old C into bit 0) and code 10 rotates right through carry (bit 0 into C, old C into bit 7); both update only C.
- R7: Code 8 exchanges the upper and lower nibbles of the operand and updates no status bit.
- R8: Code 11 returns zero, sets Z and updates only Z.
- R9: Code 12 passes the operand unchanged; with a file operand it updates only Z, with a literal operand it updates no status bit. Codes 13 to 15 also pass the operand and update no status bit.
- R10: The destination output is 1 (file register) only when the destination bit is 1 and the literal select is 0; any literal-form operation writes W.
- R11: Status bits the mask does not mark equal the incoming status bits of the same operation. Status bit order is Z in bit 2, DC in bit 1, C in bit 0, for both status ports and the mask.
- R12: The output valid flag follows the input valid flag one edge later; when no operation is accepted, result, destination, status and mask hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation selector |
| lit_sel | input | 1 | 1: second operand is the literal, 0: the file value |
| dest_bit | input | 1 | Requested destination, 1 = file register, 0 = W |
| w_opnd | input | 8 | Working-register value |
| f_opnd | input | 8 | File-register value |
| lit_opnd | input | 8 | Literal value |
| stat_in | input | 3 | Current status {Z, DC, C} |
| out_valid | output | 1 | Result registers hold a new operation |
| res_data | output | 8 | Result value |
| res_to_file | output | 1 | 1 = write to file register, 0 = write to W |
| stat_out | output | 3 | New status {Z, DC, C} |
| stat_upd | output | 3 | Status bits the operation owns |

## Verification
Every result, the destination, the status bits and the mask become due at the first rising edge after the operation is presented, and the valid flag follows on the same edge. The bench drives inputs on the falling edge, advances a behavioural model at that moment, and compares all outputs at the next falling edge, so each comparison lands half a cycle after the edge that should have produced it. Idle cycles are compared the same way, against held values, and reset is checked while it is still asserted.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int HALF_W = DATA_W / 2;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_IOR   = 4'd3,
        OP_XOR   = 4'd4,
        OP_COM   = 4'd5,
        OP_INC   = 4'd6,
        OP_DEC   = 4'd7,
        OP_SWAP  = 4'd8,
        OP_RLC   = 4'd9,
        OP_RRC   = 4'd10,
        OP_CLR   = 4'd11,
        OP_MOVE  = 4'd12,
        OP_RSV13 = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } alu_op_e;

    // bit 2 = Z, bit 1 = DC, bit 0 = C
    typedef struct packed {
        logic z;
        logic dc;
        logic c;
    } stat_t;

    function automatic stat_t owned_bits(alu_op_e op, logic lit);
        stat_t m;
        m = '0;
        case (op)
            OP_ADD, OP_SUB:                         m = '{z: 1'b1, dc: 1'b1, c: 1'b1};
            OP_AND, OP_IOR, OP_XOR,
            OP_COM, OP_INC, OP_DEC, OP_CLR:         m.z = 1'b1;
            OP_RLC, OP_RRC:                         m.c = 1'b1;
            OP_MOVE:                                m.z = !lit;
            default:                                m = '0;
        endcase
        return m;
    endfunction

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) || (op == OP_DEC);
    endfunction
endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith
    import alu8_pkg::*;
(
    input  alu_op_e              op,
    input  logic [DATA_W-1:0]    w_val,
    input  logic [DATA_W-1:0]    opnd,
    output logic [DATA_W-1:0]    sum,
    output logic                 c_out,
    output logic                 dc_out
);
    logic [DATA_W-1:0] addend;
    logic              cin;
    logic [DATA_W:0]   full;
    logic [HALF_W:0]   low;

    always_comb begin
        addend = '0;
        cin    = 1'b0;
        case (op)
            OP_ADD: addend = w_val;
            OP_SUB: begin addend = ~w_val; cin = 1'b1; end
            OP_INC: cin = 1'b1;
            OP_DEC: addend = '1;
            default: ;
        endcase
        full = {1'b0, opnd} + {1'b0, addend} + {{DATA_W{1'b0}}, cin};
        low  = {1'b0, opnd[HALF_W-1:0]} + {1'b0, addend[HALF_W-1:0]}
             + {{HALF_W{1'b0}}, cin};
    end

    assign sum    = full[DATA_W-1:0];
    assign c_out  = full[DATA_W];
    assign dc_out = low[HALF_W];
endmodule

// File: rtl/alu8_bitops.sv
`timescale 1ns/1ps
module alu8_bitops
    import alu8_pkg::*;
(
    input  alu_op_e              op,
    input  logic [DATA_W-1:0]    w_val,
    input  logic [DATA_W-1:0]    opnd,
    input  logic                 c_in,
    output logic [DATA_W-1:0]    res,
    output logic                 c_out
);
    always_comb begin
        res   = opnd;
        c_out = c_in;
        case (op)
            OP_AND:  res = opnd & w_val;
            OP_IOR:  res = opnd | w_val;
            OP_XOR:  res = opnd ^ w_val;
            OP_COM:  res = ~opnd;
            OP_SWAP: res = {opnd[HALF_W-1:0], opnd[DATA_W-1:HALF_W]};
            OP_RLC: begin
                res   = {opnd[DATA_W-2:0], c_in};
                c_out = opnd[DATA_W-1];
            end
            OP_RRC: begin
                res   = {c_in, opnd[DATA_W-1:1]};
                c_out = opnd[0];
            end
            OP_CLR:  res = '0;
            default: res = opnd;
        endcase
    end
endmodule

// File: rtl/accu_alu.sv
`timescale 1ns/1ps
module accu_alu
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [3:0]  op_code,
    input  logic        lit_sel,
    input  logic        dest_bit,
    input  logic [7:0]  w_opnd,
    input  logic [7:0]  f_opnd,
    input  logic [7:0]  lit_opnd,
    input  logic [2:0]  stat_in,
    output logic        out_valid,
    output logic [7:0]  res_data,
    output logic        res_to_file,
    output logic [2:0]  stat_out,
    output logic [2:0]  stat_upd
);
    alu_op_e           op;
    stat_t             cur, cand, mask, merged;
    logic [DATA_W-1:0] opnd, ar_sum, bo_res, result;
    logic              ar_c, ar_dc, bo_c;

    assign op   = alu_op_e'(op_code);
    assign cur  = stat_t'(stat_in);
    assign opnd = lit_sel ? lit_opnd : f_opnd;

    alu8_arith u_arith (
        .op(op), .w_val(w_opnd), .opnd(opnd),
        .sum(ar_sum), .c_out(ar_c), .dc_out(ar_dc)
    );

    alu8_bitops u_bitops (
        .op(op), .w_val(w_opnd), .opnd(opnd), .c_in(cur.c),
        .res(bo_res), .c_out(bo_c)
    );

    always_comb begin
        result  = is_arith(op) ? ar_sum : bo_res;
        cand.z  = (result == '0);
        cand.dc = ar_dc;
        cand.c  = is_arith(op) ? ar_c : bo_c;
        mask    = owned_bits(op, lit_sel);
        merged  = (cand & mask) | (cur & ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            res_data    <= '0;
            res_to_file <= 1'b0;
            stat_out    <= '0;
            stat_upd    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_data    <= result;
                res_to_file <= dest_bit && !lit_sel;
                stat_out    <= merged;
                stat_upd    <= mask;
            end
        end
    end

    // R2
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && ($past(op_code) == 4'd0)
        |-> {stat_out[0], res_data} ==
            ({1'b0, $past(w_opnd)} + {1'b0, ($past(lit_sel) ? $past(lit_opnd) : $past(f_opnd))}));

    // R6
    rot_left_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && ($past(op_code) == 4'd9)
        |-> (stat_out[0] == $past(opnd[DATA_W-1])) && (res_data[0] == $past(stat_in[0])));

    // R10
    lit_to_w_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(lit_sel) |-> !res_to_file);

    // R11
    keep_unowned_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((stat_out ^ $past(stat_in)) & ~stat_upd) == 3'b000);

    // R2 R3 R4 R5 R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && stat_upd[2] |-> stat_out[2] == (res_data == 8'h00));
endmodule

// File: tb/accu_alu_bench.sv
`timescale 1ns/1ps
module accu_alu_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic       lit_sel = 1'b0;
    logic       dest_bit = 1'b0;
    logic [7:0] w_opnd = '0, f_opnd = '0, lit_opnd = '0;
    logic [2:0] stat_in = '0;
    logic       out_valid;
    logic [7:0] res_data;
    logic       res_to_file;
    logic [2:0] stat_out, stat_upd;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    int e_valid = 0, e_res = 0, e_file = 0, e_stat = 0, e_upd = 0;
    string e_tag = "R1";

    always #10 clk = ~clk;

    accu_alu u_accu_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .lit_sel(lit_sel), .dest_bit(dest_bit), .w_opnd(w_opnd),
        .f_opnd(f_opnd), .lit_opnd(lit_opnd), .stat_in(stat_in),
        .out_valid(out_valid), .res_data(res_data), .res_to_file(res_to_file),
        .stat_out(stat_out), .stat_upd(stat_upd)
    );

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    function automatic string tag_of(int op, int lit);
        case (op)
            0: return "R2";
            1: return "R3";
            2, 3, 4: return "R4";
            5, 6, 7: return "R5";
            8: return "R7";
            9, 10: return "R6";
            11: return "R8";
            default: return (lit != 0) ? "R9 (literal)" : "R9";
        endcase
    endfunction

    // behavioural model of one accepted operation
    task automatic model(int v, int op, int lit, int d, int w, int f, int k, int s);
        int o, r, c, dc, z, m, cold;
        if (v == 0) begin
            e_valid = 0;
            e_tag = "R12";
            return;
        end
        o = (lit != 0) ? k : f;
        cold = s & 1;
        c = 0; dc = 0; m = 0; r = o;
        case (op)
            0: begin r = o + w; c = (r > 255); dc = ((o % 16) + (w % 16)) > 15; m = 7; end
            1: begin r = o - w; c = (o >= w); dc = ((o % 16) >= (w % 16)); m = 7; end
            2: begin r = o & w; m = 4; end
            3: begin r = o | w; m = 4; end
            4: begin r = o ^ w; m = 4; end
            5: begin r = 255 - o; m = 4; end
            6: begin r = o + 1; m = 4; end
            7: begin r = o - 1; m = 4; end
            8: begin r = (o % 16) * 16 + o / 16; m = 0; end
            9: begin r = o * 2 + cold; c = o / 128; m = 1; end
            10: begin r = cold * 128 + o / 2; c = o % 2; m = 1; end
            11: begin r = 0; m = 4; end
            12: begin r = o; m = (lit != 0) ? 0 : 4; end
            default: begin r = o; m = 0; end
        endcase
        r = r & 255;
        z = (r == 0);
        e_valid = 1;
        e_res = r;
        e_file = (d != 0 && lit == 0);
        e_upd = m;
        e_stat = (s & ~m & 7) | (m & ((z * 4) + (dc * 2) + c));
        e_tag = tag_of(op, lit);
    endtask

    task automatic compare();
        bit bad = 0;
        n_cmp++;
        if (out_valid !== e_valid[0]) begin
            bad = 1;
            $display("FAIL R12 out_valid: actual %0b expected %0d", out_valid, e_valid);
        end
        if (res_data !== e_res[7:0]) begin
            bad = 1;
            $display("FAIL %s result: actual %02h expected %02h", e_tag, res_data, e_res[7:0]);
        end
        if (res_to_file !== e_file[0]) begin
            bad = 1;
            $display("FAIL R10 destination: actual %0b expected %0d", res_to_file, e_file);
        end
        if (stat_out !== e_stat[2:0]) begin
            bad = 1;
            $display("FAIL %s/R11 status: actual %03b expected %03b", e_tag, stat_out, e_stat[2:0]);
        end
        if (stat_upd !== e_upd[2:0]) begin
            bad = 1;
            $display("FAIL %s mask: actual %03b expected %03b", e_tag, stat_upd, e_upd[2:0]);
        end
        if (bad) n_bad++;
    endtask

    // drive at falling edge, compare at next falling edge
    task automatic step(int v, int op, int lit, int d, int w, int f, int k, int s);
        in_valid = v[0];
        op_code  = op[3:0];
        lit_sel  = lit[0];
        dest_bit = d[0];
        w_opnd   = w[7:0];
        f_opnd   = f[7:0];
        lit_opnd = k[7:0];
        stat_in  = s[2:0];
        model(v, op, lit, d, w, f, k, s);
        @(negedge clk);
        compare();
    endtask

    initial begin
        // R1: reset with garbage inputs applied
        in_valid = 1'b1; op_code = 4'd0; f_opnd = 8'hFF; w_opnd = 8'h01; stat_in = 3'b111;
        repeat (3) @(negedge clk);
        e_valid = 0; e_res = 0; e_file = 0; e_stat = 0; e_upd = 0; e_tag = "R1";
        compare();
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        // R2 add
        step(1, 0, 0, 1, 8'h01, 8'h0F, 0, 3'b000);   // DC only
        step(1, 0, 0, 0, 8'h01, 8'hFF, 0, 3'b000);   // C, DC, Z
        step(1, 0, 1, 1, 8'h20, 0, 8'h30, 3'b111);   // literal add, no flags
        // R3 subtract
        step(1, 1, 0, 1, 8'h05, 8'h05, 0, 3'b000);   // equal: C=1 DC=1 Z=1
        step(1, 1, 0, 1, 8'h05, 8'h03, 0, 3'b111);   // borrow: C=0
        step(1, 1, 1, 0, 8'h01, 0, 8'h10, 3'b000);   // nibble borrow: DC=0 C=1
        // R4 logic
        step(1, 2, 0, 1, 8'h0F, 8'hF0, 0, 3'b011);   // AND to zero
        step(1, 3, 1, 1, 8'h0F, 0, 8'hF0, 3'b111);   // OR literal
        step(1, 4, 0, 0, 8'hAA, 8'hAA, 0, 3'b000);   // XOR to zero
        // R5
        step(1, 5, 0, 1, 0, 8'hFF, 0, 3'b011);
        step(1, 6, 0, 1, 0, 8'hFF, 0, 3'b000);
        step(1, 7, 0, 1, 0, 8'h01, 0, 3'b011);
        step(1, 7, 0, 1, 0, 8'h00, 0, 3'b111);
        // R6 rotates
        step(1, 9, 0, 1, 0, 8'h80, 0, 3'b010);
        step(1, 9, 0, 1, 0, 8'h00, 0, 3'b001);
        step(1, 10, 0, 0, 0, 8'h01, 0, 3'b001);
        step(1, 10, 0, 0, 0, 8'hFE, 0, 3'b100);
        // R7 swap
        step(1, 8, 0, 1, 0, 8'hA5, 0, 3'b101);
        step(1, 8, 0, 1, 0, 8'h00, 0, 3'b010);
        // R8 clear
        step(1, 11, 0, 1, 8'h33, 8'h77, 0, 3'b011);
        step(1, 11, 0, 0, 8'h33, 8'h77, 0, 3'b000);
        // R9 move
        step(1, 12, 0, 1, 0, 8'h00, 0, 3'b000);
        step(1, 12, 0, 0, 0, 8'h42, 0, 3'b111);
        step(1, 12, 1, 1, 0, 0, 8'h00, 3'b000);
        step(1, 14, 0, 1, 0, 8'h00, 0, 3'b010);
        // R10 literal forces W
        step(1, 2, 1, 1, 8'hFF, 0, 8'h3C, 3'b000);
        // R12 idle cycles hold
        step(0, 0, 0, 1, 8'h11, 8'h22, 0, 3'b111);
        step(0, 5, 1, 0, 8'h00, 8'h00, 0, 3'b000);
        step(1, 1, 0, 1, 8'h80, 8'h7F, 0, 3'b010);

        // random sweep, all requirements
        for (int i = 0; i < 2000; i++) begin
            step(($urandom % 8) != 0, $urandom % 16, $urandom % 2, $urandom % 2,
                 $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 8);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule